// File: doc/BRIEF.md
# Rotate-and-Mask Condition Flag Loader

This execution unit handles one integer instruction. It takes a 64-bit register operand, rotates it right by a six-bit immediate, and takes the low four bits of the rotated value. Those bits are written into a four-bit condition flag register, one flag at a time, under a four-bit write mask. The unit decodes the 32-bit instruction word itself. When the feature strap is low, a matching instruction produces an undefined-instruction pulse. A word that does not match the encoding is ignored, so another decoder can claim it. The unit also presents the source register index, so the operand can be fetched elsewhere.

Every accepted instruction completes at the first clock edge after its valid strobe. The cost is the same for every operand and every flag value, which meets the data-independent timing rule without a separate mode.

The control is a small state machine with three named states:
- `ST_IDLE`: the previous cycle retired nothing.
- `ST_COMMIT`: the previous cycle wrote the flags.
- `ST_TRAP`: the previous cycle raised the undefined indication.

Each edge moves the machine from any state to one of these three:
- **take_commit**: a valid, matching word with the strap set.
- **take_trap**: a valid, matching word with the strap clear.
- **go_idle**: anything else.

Top module: `flag_insert_unit`

## Requirements
- R1: A synchronous reset clears the flag bus to 0000 and holds `done_o` and `undef_o` low.
- R2: An instruction word is recognised only when all three of these hold:
  - bits 31..21 are 10111010000;
  - bits 14..10 are 00001;
  - bit 4 is 0.
- R3: The field layout is fixed:
  - bits 20..15 hold the rotate amount `lsb`, read as an unsigned number from 0 to 63;
  - bits 3..0 hold the write mask.
- R4: Selected bit k, for k = 0..3, is operand bit (lsb+k) mod 64, so amounts 61 to 63 wrap to bit 0.
- R5: The flag bus is ordered N, Z, C, V from bit 3 down to bit 0. Mask bit k loads flag bit k from selected bit k.
- R6: A flag whose mask bit is 0 keeps its previous value.
- R7: For a valid, matching word with `feat_en_i` low:
  - `undef_o` is high for exactly the following cycle;
  - the flags are unchanged;
  - `done_o` stays low.
- R8: A word with `valid_i` low, or a word that does not match, causes no flag change, no `done_o` and no `undef_o`.
- R9: For a valid, matching word with `feat_en_i` high:
  - `done_o` is high in the cycle after the strobe;
  - the new flags are visible in that same cycle;
  - this latency does not depend on the operand or on the current flags.
  - Back-to-back strobes each complete.
- R10: `src_idx_o` equals instruction bits 9..5 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction word and operand are valid this cycle |
| insn_i | input | 32 | Instruction word |
| operand_i | input | 64 | Source register value |
| feat_en_i | input | 1 | Flag-manipulation feature enable strap |
| src_idx_o | output | 5 | Source register index decoded from the word |
| flags_o | output | 4 | Condition flags {N, Z, C, V} |
| done_o | output | 1 | Flag update retired (one cycle after the strobe) |
| undef_o | output | 1 | Undefined-instruction indication |

## Verification
The assertions assume that `insn_i`, `valid_i` and `feat_en_i` stay fixed during the cycle they are sampled in. They also assume that reset is asserted at time zero, because the reset property and every `$past` reference count from then. The stimulus meets both assumptions:
- every input changes only on the falling clock edge;
- reset is held for the first cycles;
- the strobe is dropped after the last instruction, so the hold checks see a quiet bus.

The sweep covers every rotate amount with every mask under random operands.

// File: rtl/fim_pkg.sv
package fim_pkg;

    localparam int INSN_W  = 32;
    localparam int FLAG_W  = 4;
    localparam int ROT_W   = 6;
    localparam int SRC_W   = 5;

    localparam logic [10:0] OPC_HI  = 11'b101_1101_0000;
    localparam logic [4:0]  OPC_MID = 5'b00001;
    localparam logic        OPC_LO  = 1'b0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_TRAP   = 2'd2
    } fim_state_e;

    typedef struct packed {
        logic              hit;
        logic [ROT_W-1:0]  lsb;
        logic [SRC_W-1:0]  src;
        logic [FLAG_W-1:0] wmask;
    } fim_dec_t;

endpackage

// File: rtl/fim_decode.sv
module fim_decode
    import fim_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output fim_dec_t          dec_o
);
    logic hi_ok, mid_ok, lo_ok;

    always_comb begin
        hi_ok  = (insn_i[31:21] == OPC_HI);
        mid_ok = (insn_i[14:10] == OPC_MID);
        lo_ok  = (insn_i[4] == OPC_LO);
        dec_o.hit   = hi_ok & mid_ok & lo_ok;
        dec_o.lsb   = insn_i[20:15];
        dec_o.src   = insn_i[9:5];
        dec_o.wmask = insn_i[3:0];
    end
endmodule

// File: rtl/fim_rotsel.sv
module fim_rotsel #(
    parameter int DATA_W  = 64,
    parameter int TAP_N   = 4,
    localparam int SHIFT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [SHIFT_W-1:0] lsb_i,
    output logic [TAP_N-1:0]   sel_o
);
    // Each tap index wraps modulo DATA_W through the width of its adder.
    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        logic [SHIFT_W-1:0] idx;
        assign idx      = lsb_i + SHIFT_W'(k);
        assign sel_o[k] = data_i[idx];
    end
endmodule

// File: rtl/fim_flagreg.sv
module fim_flagreg #(
    parameter int FLAG_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] wr_en_i,
    input  logic [FLAG_N-1:0] wr_val_i,
    output logic [FLAG_N-1:0] flags_o
);
    for (genvar k = 0; k < FLAG_N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags_o[k] <= 1'b0;
            else if (wr_en_i[k])
                flags_o[k] <= wr_val_i[k];
        end
    end
endmodule

// File: rtl/flag_insert_unit.sv
module flag_insert_unit
    import fim_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              feat_en_i,
    output logic [4:0]        src_idx_o,
    output logic [3:0]        flags_o,
    output logic              done_o,
    output logic              undef_o
);
    localparam int SHIFT_W = $clog2(DATA_W);

    fim_dec_t           dec;
    logic [FLAG_W-1:0]  picked;
    logic [FLAG_W-1:0]  wr_en;
    logic               take_commit;
    logic               take_trap;
    fim_state_e         state_q, state_d;

    fim_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    fim_rotsel #(
        .DATA_W (DATA_W),
        .TAP_N  (FLAG_W)
    ) u_rot (
        .data_i (operand_i),
        .lsb_i  (SHIFT_W'(dec.lsb)),
        .sel_o  (picked)
    );

    fim_flagreg #(
        .FLAG_N (FLAG_W)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en),
        .wr_val_i (picked),
        .flags_o  (flags_o)
    );

    assign take_commit = valid_i & dec.hit & feat_en_i;
    assign take_trap   = valid_i & dec.hit & ~feat_en_i;
    assign wr_en       = {FLAG_W{take_commit}} & dec.wmask;
    assign src_idx_o   = dec.src;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_COMMIT, ST_TRAP: begin
                if (take_commit)
                    state_d = ST_COMMIT;
                else if (take_trap)
                    state_d = ST_TRAP;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        done_o  = 1'b0;
        undef_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: done_o  = 1'b1;
            ST_TRAP:   undef_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/fim_checker.sv
module fim_checker (
    input logic       clk,
    input logic       rst,
    input logic       valid_i,
    input logic       feat_en_i,
    input logic [3:0] wmask_i,
    input logic [3:0] flags_o,
    input logic       done_o,
    input logic       undef_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (flags_o == 4'b0000 && !done_o && !undef_o));

    a_r7_exclusive_pulses: assert property (@(posedge clk) disable iff (rst)
        !(done_o && undef_o));

    a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> ($past(valid_i) && !$past(feat_en_i)));

    a_r9_done_cause: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(valid_i) && $past(feat_en_i)));

    a_r8_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(flags_o));

    a_r6_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (((flags_o ^ $past(flags_o)) & ~$past(wmask_i)) == 4'b0000));
endmodule

bind flag_insert_unit fim_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .feat_en_i (feat_en_i),
    .wmask_i   (insn_i[3:0]),
    .flags_o   (flags_o),
    .done_o    (done_o),
    .undef_o   (undef_o)
);

// File: tb/tb_flag_insert_unit.sv
`timescale 1ns/1ps
module tb_flag_insert_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] insn_i;
    logic [63:0] operand_i;
    logic        feat_en_i;
    logic [4:0]  src_idx_o;
    logic [3:0]  flags_o;
    logic        done_o;
    logic        undef_o;

    int compared = 0;
    int mismatched = 0;
    logic [3:0] model = 4'b0000;

    always #2.5 clk = ~clk;

    flag_insert_unit dut (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (valid_i),
        .insn_i    (insn_i),
        .operand_i (operand_i),
        .feat_en_i (feat_en_i),
        .src_idx_o (src_idx_o),
        .flags_o   (flags_o),
        .done_o    (done_o),
        .undef_o   (undef_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int sh, input int rn, input int msk);
        logic [31:0] w = 32'hBA00_0400;
        w[20:15] = 6'(sh);
        w[9:5]   = 5'(rn);
        w[3:0]   = 4'(msk);
        return w;
    endfunction

    function automatic logic [3:0] pick(input logic [63:0] op, input int sh);
        logic [127:0] dbl = {op, op};
        return dbl[sh +: 4];
    endfunction

    // Called at a falling edge; returns at the next falling edge with results checked.
    task automatic issue(input logic [31:0] w, input logic [63:0] op, input logic fe,
                         input logic hit, input int sh, input int msk);
        logic [3:0] sel = pick(op, sh);
        logic [3:0] m4 = 4'(msk);
        valid_i = 1'b1; insn_i = w; operand_i = op; feat_en_i = fe;
        #0.1;
        check("R10 src index", 64'(src_idx_o), 64'(w[9:5]));
        @(negedge clk);
        valid_i = 1'b0;
        if (hit && fe) model = (model & ~m4) | (sel & m4);
        check("R9 done pulse", 64'(done_o), 64'(hit && fe));
        check("R7 undef pulse", 64'(undef_o), 64'(hit && !fe));
        check("R4 R5 R6 flags", 64'(flags_o), 64'(model));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; insn_i = '0; operand_i = '0; feat_en_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset flags", 64'(flags_o), 64'h0);
        check("R1 reset done", 64'(done_o), 64'h0);
        check("R1 reset undef", 64'(undef_o), 64'h0);
        rst = 1'b0;

        // R3 R4: lsb 0 and wrap cases 61..63 with a known pattern.
        issue(enc(0, 3, 15), 64'h0000_0000_0000_000A, 1'b1, 1'b1, 0, 15);
        issue(enc(61, 7, 15), 64'h8000_0000_0000_0001, 1'b1, 1'b1, 61, 15);
        issue(enc(62, 1, 15), 64'h4000_0000_0000_0003, 1'b1, 1'b1, 62, 15);
        issue(enc(63, 31, 15), 64'h8000_0000_0000_0005, 1'b1, 1'b1, 63, 15);
        // R6: zero mask keeps everything.
        issue(enc(5, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 5, 0);
        // R7: feature disabled traps, flags unchanged.
        issue(enc(8, 2, 15), 64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 8, 15);
        // R2 R8: non-matching words (bit 4, bit 21, bit 11 altered).
        issue(enc(4, 2, 15) | 32'h10, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4, 15);
        issue(enc(4, 2, 15) | 32'h0020_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4, 15);
        issue(enc(4, 2, 15) | 32'h800, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 4, 15);
        // R8: valid low must not update.
        insn_i = enc(0, 0, 15); operand_i = '1; feat_en_i = 1'b1;
        @(negedge clk);
        check("R8 idle no done", 64'(done_o), 64'h0);
        check("R8 idle flags", 64'(flags_o), 64'(model));

        // R4 R5 R6 R9: every shift with every mask, random operands, back to back.
        for (int sh = 0; sh < 64; sh++) begin
            for (int msk = 0; msk < 16; msk++) begin
                logic [63:0] op = {$urandom(), $urandom()};
                issue(enc(sh, $urandom_range(0, 31), msk), op, 1'b1, 1'b1, sh, msk);
            end
        end
        // R7 interleaved with commits.
        for (int i = 0; i < 32; i++) begin
            logic fe = 1'($urandom_range(0, 1));
            int sh = $urandom_range(0, 63);
            int msk = $urandom_range(0, 15);
            issue(enc(sh, i, msk), {$urandom(), $urandom()}, fe, 1'b1, sh, msk);
        end
        @(negedge clk);
        check("R8 quiet after run", 64'(flags_o), 64'(model));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule